// File: doc/BRIEF.md
# Configurable Multi-Port Memory Array

A behavioural, synthesizable storage array with a parameterized number of ports. Any port can be set up to read, to write, or to do both. Each port has its own read latency and its own write-lane granularity, and it can use per-lane write masking or whole-word writes. All ports run either on one common clock or, when the independent-clock option is set, each on its own clock. The array is meant to stand in for a technology memory in simulation and in flip-flop builds.

Each port takes an address, a request strobe, a write-enable, write data and a lane mask. It returns read data with a valid pulse after that port's fixed number of cycles. Reset loads the initial contents, which are all ones, all zeros, a repeatable pseudo-random pattern, or no defined value. Reset also clears every read pipeline.

Top module: `mem_multiport`

## Requirements
- R1: Reset clears every read-valid output. After reset, each word reads as the initialization pattern. The default configuration uses the all-ones pattern, so every word reads 0xFFFF.
- R2: A request on a read-capable port with latency N raises that port's read-valid exactly N rising edges after the edge that accepted it. The output carries that word. Read-valid is low at every other time. The defaults are N=1 for port 0 and N=3 for port 1.
- R3: A read-capable port accepts one request per cycle. Back-to-back requests come out on consecutive cycles, in order.
- R4: A masked write changes only the lanes whose mask bit is 1. Mask bit i covers data bits i*B up to min((i+1)*B, W)-1, where B is the port's lane width. Port 0 uses B=8 on W=16.
- R5: When B does not divide W, the top lane is narrower. Port 1 has B=6, so its mask bit 2 covers bits 15:12 only.
- R6: A port built without masking writes the whole word and ignores its mask input. Port 2 is built this way.
- R7: A write-only port holds read-valid and read data at 0. A request on it with write-enable low changes no stored word. Port 2 is write-only.
- R8: A request with write-enable high on a read-write port returns the word as it stood before that write.
- R9: When ports write the same address in the same cycle, each bit takes the value from the highest-numbered port that writes that bit.
- R10: A write to an address at or above the word count changes nothing. A read of such an address returns 0 with a normal valid pulse.
- R11: A word written through one port is visible to every other port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | NUM_PORTS | Port clocks; only bit 0 is used unless INDEP_CLK is set |
| rst_i | input | 1 | Synchronous active-high reset, seen on each port clock |
| req_i | input | NUM_PORTS | Per-port request strobe |
| we_i | input | NUM_PORTS | Per-port write-enable, qualified by req_i |
| addr_i | input | NUM_PORTS*ADDR_W | Per-port word address |
| wdata_i | input | NUM_PORTS*DATA_W | Per-port write data |
| be_i | input | NUM_PORTS*MASK_W | Per-port lane mask, bit i for lane i |
| rdata_o | output | NUM_PORTS*DATA_W | Per-port read data, 0 when not valid |
| rvalid_o | output | NUM_PORTS | Per-port read-data-valid pulse |

## Verification
The bench targets these failures:
- Lane decoding on the truncated top lane of port 1. A design that rounds that lane to a full six bits would clear bits that belong to nothing, or would drop bits 15:12.
- Same-cycle writes to one word, including a partial overlap. A design that picks one winner per word, rather than per bit, would lose the lower port's untouched bits. A design that resolves priority the wrong way would return the lower port's data.
- Read-first behaviour, and back-to-back reads on the three-cycle port. Each of these shows stale or skewed data when a pipeline stage is missing or shared.
- Out-of-range addresses and write-enable-low requests on the write-only port. A wrapped address or an unguarded write would corrupt a real word, which a later read would expose.

// File: rtl/mem_mp_pkg.sv
package mem_mp_pkg;

    // Contents loaded when reset is applied
    typedef enum logic [1:0] {
        INIT_NONE   = 2'd0,
        INIT_ONES   = 2'd1,
        INIT_ZEROS  = 2'd2,
        INIT_RANDOM = 2'd3
    } mem_init_e;

    localparam logic [31:0] RAND_SEED = 32'hACE1_2468;
    localparam logic [31:0] RAND_TAPS = 32'h8020_0003;

    // Number of write lanes for a word of w bits split in lanes of bw bits
    function automatic int unsigned lane_count(int unsigned w, int unsigned bw);
        return (w + bw - 1) / bw;
    endfunction

    // One Galois LFSR step
    function automatic logic [31:0] lfsr_step(logic [31:0] s);
        return s[0] ? ((s >> 1) ^ RAND_TAPS) : (s >> 1);
    endfunction

    // Repeatable per-word starting value for the pseudo-random fill
    function automatic logic [31:0] rand_seed_word(int unsigned idx);
        logic [31:0] s;
        s = RAND_SEED ^ idx;
        for (int unsigned k = 0; k < 4; k++) begin
            s = lfsr_step(s);
        end
        return s;
    endfunction

endpackage

// File: rtl/mem_mp_lanes.sv
// Expands a lane mask into a per-bit enable; the top lane may be narrow.
module mem_mp_lanes #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned MASK_W   = 2,
    parameter bit          USE_MASK = 1'b1
) (
    input  logic [MASK_W-1:0] mask_i,
    output logic [DATA_W-1:0] bit_en_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (USE_MASK) begin : g_masked
            assign bit_en_o[b] = mask_i[b / BYTE_W];
        end else begin : g_full
            assign bit_en_o[b] = 1'b1;
        end
    end
endmodule

// File: rtl/mem_mp_rd_pipe.sv
// Fixed-length read delay line, one request per cycle.
module mem_mp_rd_pipe #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned LATENCY = 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t stg_q [LATENCY];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int unsigned i = 0; i < LATENCY; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q[0] <= '{vld: vld_i, data: data_i};
            for (int unsigned i = 1; i < LATENCY; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign vld_o  = stg_q[LATENCY-1].vld;
    assign data_o = stg_q[LATENCY-1].data;
endmodule

// File: rtl/mem_mp_bank.sv
// One storage bank; the stored word is the XOR of all banks, so each
// port owns a bank and no storage bit is driven from two clock domains.
module mem_mp_bank
    import mem_mp_pkg::*;
#(
    parameter int unsigned WORDS      = 12,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 4,
    parameter mem_init_e   INIT       = INIT_ONES,
    parameter bit          HOLDS_INIT = 1'b0,
    parameter bit          CAN_WRITE  = 1'b1
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             bit_en_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic [DATA_W-1:0]             others_i,
    output logic [WORDS-1:0][DATA_W-1:0]  bank_o
);
    localparam int unsigned SEG = (DATA_W + 31) / 32;

    logic [WORDS-1:0][DATA_W-1:0] bank_q;

    function automatic logic [DATA_W-1:0] rand_fill(int unsigned idx);
        logic [SEG*32-1:0] acc;
        logic [31:0]       s;
        s = rand_seed_word(idx);
        for (int unsigned k = 0; k < SEG; k++) begin
            acc[k*32 +: 32] = s;
            s = lfsr_step(s);
        end
        return acc[DATA_W-1:0];
    endfunction

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int unsigned w = 0; w < WORDS; w++) begin
                if (!HOLDS_INIT)                bank_q[w] <= '0;
                else if (INIT == INIT_ONES)     bank_q[w] <= '1;
                else if (INIT == INIT_ZEROS)    bank_q[w] <= '0;
                else if (INIT == INIT_RANDOM)   bank_q[w] <= rand_fill(w);
            end
        end else if (CAN_WRITE && wr_i) begin
            bank_q[addr_i] <= (bank_q[addr_i] & ~bit_en_i)
                            | ((wdata_i ^ others_i) & bit_en_i);
        end
    end

    assign bank_o = bank_q;
endmodule

// File: rtl/mem_multiport.sv
module mem_multiport
    import mem_mp_pkg::*;
#(
    parameter int unsigned          NUM_PORTS = 3,
    parameter int unsigned          WORDS     = 12,
    parameter int unsigned          DATA_W    = 16,
    parameter int unsigned          ADDR_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
    parameter int unsigned          MASK_W    = 3,
    parameter bit                   INDEP_CLK = 1'b0,
    parameter mem_init_e            INIT      = INIT_ONES,
    parameter logic [NUM_PORTS-1:0] PORT_RD   = 3'b011,
    parameter logic [NUM_PORTS-1:0] PORT_WR   = 3'b111,
    parameter logic [NUM_PORTS-1:0] PORT_MASK = 3'b011,
    parameter int unsigned          RD_LAT [NUM_PORTS] = '{1, 3, 1},
    parameter int unsigned          BYTE_W [NUM_PORTS] = '{8, 6, 16}
) (
    input  logic [NUM_PORTS-1:0]              clk_i,
    input  logic                              rst_i,
    input  logic [NUM_PORTS-1:0]              req_i,
    input  logic [NUM_PORTS-1:0]              we_i,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata_i,
    input  logic [NUM_PORTS-1:0][MASK_W-1:0]  be_i,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_o,
    output logic [NUM_PORTS-1:0]              rvalid_o
);
    localparam logic [ADDR_W:0] LIMIT = WORDS[ADDR_W:0];

    logic [NUM_PORTS-1:0][WORDS-1:0][DATA_W-1:0] bank_all;
    logic [WORDS-1:0][DATA_W-1:0]                view;
    logic [NUM_PORTS-1:0]                        in_range, wr_ok, rd_fire;
    logic [NUM_PORTS-1:0][ADDR_W-1:0]            idx_c;
    logic [NUM_PORTS-1:0][DATA_W-1:0]            raw_en, eff_en, others, rd_word;

    // Logical contents: XOR across all banks
    always_comb begin
        view = '0;
        for (int unsigned p = 0; p < NUM_PORTS; p++) begin
            view ^= bank_all[p];
        end
    end

    always_comb begin
        for (int unsigned p = 0; p < NUM_PORTS; p++) begin
            in_range[p] = {1'b0, addr_i[p]} < LIMIT;
            idx_c[p]    = in_range[p] ? addr_i[p] : '0;
            wr_ok[p]    = PORT_WR[p] & req_i[p] & we_i[p] & in_range[p];
            rd_fire[p]  = PORT_RD[p] & req_i[p];
            rd_word[p]  = (rd_fire[p] && in_range[p]) ? view[idx_c[p]] : '0;
            others[p]   = view[idx_c[p]] ^ bank_all[p][idx_c[p]];
        end
    end

    // Same-cycle collisions on a shared clock: higher port wins per bit
    always_comb begin
        for (int unsigned p = 0; p < NUM_PORTS; p++) begin
            eff_en[p] = raw_en[p];
            if (!INDEP_CLK) begin
                for (int unsigned q = p + 1; q < NUM_PORTS; q++) begin
                    if (wr_ok[q] && (addr_i[q] == addr_i[p])) begin
                        eff_en[p] &= ~raw_en[q];
                    end
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic pclk;
        if (INDEP_CLK) begin : g_own_clk
            assign pclk = clk_i[p];
        end else begin : g_shared_clk
            assign pclk = clk_i[0];
        end

        mem_mp_lanes #(
            .DATA_W   (DATA_W),
            .BYTE_W   (BYTE_W[p]),
            .MASK_W   (MASK_W),
            .USE_MASK (PORT_MASK[p])
        ) u_lanes (
            .mask_i   (be_i[p]),
            .bit_en_o (raw_en[p])
        );

        mem_mp_bank #(
            .WORDS      (WORDS),
            .DATA_W     (DATA_W),
            .ADDR_W     (ADDR_W),
            .INIT       (INIT),
            .HOLDS_INIT (p == 0),
            .CAN_WRITE  (PORT_WR[p])
        ) u_bank (
            .clk_i    (pclk),
            .rst_i    (rst_i),
            .wr_i     (wr_ok[p]),
            .addr_i   (idx_c[p]),
            .bit_en_i (eff_en[p]),
            .wdata_i  (wdata_i[p]),
            .others_i (others[p]),
            .bank_o   (bank_all[p])
        );

        if (PORT_RD[p]) begin : g_rd
            mem_mp_rd_pipe #(
                .DATA_W  (DATA_W),
                .LATENCY (RD_LAT[p])
            ) u_pipe (
                .clk_i  (pclk),
                .rst_i  (rst_i),
                .vld_i  (rd_fire[p]),
                .data_i (rd_word[p]),
                .vld_o  (rvalid_o[p]),
                .data_o (rdata_o[p])
            );
        end else begin : g_no_rd
            assign rvalid_o[p] = 1'b0;
            assign rdata_o[p]  = '0;
        end
    end
endmodule

// File: rtl/mem_mp_chk.sv
module mem_mp_chk #(
    parameter int unsigned          NUM_PORTS = 3,
    parameter int unsigned          WORDS     = 12,
    parameter int unsigned          DATA_W    = 16,
    parameter int unsigned          ADDR_W    = 4,
    parameter bit                   INDEP_CLK = 1'b0,
    parameter logic [NUM_PORTS-1:0] PORT_RD   = 3'b011,
    parameter int unsigned          RD_LAT [NUM_PORTS] = '{1, 3, 1}
) (
    input logic [NUM_PORTS-1:0]              clk_i,
    input logic                              rst_i,
    input logic [NUM_PORTS-1:0]              req_i,
    input logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
    input logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_o,
    input logic [NUM_PORTS-1:0]              rvalid_o
);
    localparam logic [ADDR_W:0] LIMIT = WORDS[ADDR_W:0];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        logic pclk;
        if (INDEP_CLK) begin : g_own_clk
            assign pclk = clk_i[p];
        end else begin : g_shared_clk
            assign pclk = clk_i[0];
        end

        if (PORT_RD[p]) begin : g_rd
            localparam int unsigned L = RD_LAT[p];
            logic [L-1:0] v_hist, o_hist;
            logic         oob;
            assign oob = {1'b0, addr_i[p]} >= LIMIT;

            always_ff @(posedge pclk) begin
                if (rst_i) begin
                    v_hist <= '0;
                    o_hist <= '0;
                end else begin
                    v_hist <= (v_hist << 1) | L'(req_i[p]);
                    o_hist <= (o_hist << 1) | L'(req_i[p] & oob);
                end
            end

            assert_rvalid_timing_R2: assert property (@(posedge pclk) disable iff (rst_i)
                rvalid_o[p] == v_hist[L-1]);
            assert_oob_zero_R10: assert property (@(posedge pclk) disable iff (rst_i)
                o_hist[L-1] |-> (rdata_o[p] == '0));
            assert_reset_quiet_R1: assert property (@(posedge pclk) disable iff (rst_i)
                $fell(rst_i) |-> !rvalid_o[p]);
        end else begin : g_wo
            assert_wo_quiet_R7: assert property (@(posedge pclk) disable iff (rst_i)
                req_i[p] |=> (!rvalid_o[p] && rdata_o[p] == '0));
        end
    end
endmodule

bind mem_multiport mem_mp_chk #(
    .NUM_PORTS (NUM_PORTS),
    .WORDS     (WORDS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .INDEP_CLK (INDEP_CLK),
    .PORT_RD   (PORT_RD),
    .RD_LAT    (RD_LAT)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .req_i    (req_i),
    .addr_i   (addr_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
);

// File: tb/sim_mem_multiport.sv
module sim_mem_multiport;
    localparam int unsigned NP = 3;
    localparam int unsigned AW = 4;
    localparam int unsigned DW = 16;
    localparam int unsigned MW = 3;

    // 125 MHz: 8 ns period
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                    rst;
    logic [NP-1:0]           req, we, rvalid;
    logic [NP-1:0][AW-1:0]   addr;
    logic [NP-1:0][DW-1:0]   wdata, rdata;
    logic [NP-1:0][MW-1:0]   be;
    logic                    done = 1'b0;
    int                      checks = 0;
    int                      fails  = 0;

    mem_multiport u0 (
        .clk_i    ({NP{clk}}),
        .rst_i    (rst),
        .req_i    (req),
        .we_i     (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .be_i     (be),
        .rdata_o  (rdata),
        .rvalid_o (rvalid)
    );

    typedef struct packed {
        logic [1:0]  port;
        logic        wr;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [2:0]  mask;
        logic [15:0] exp;
    } vec_t;

    localparam int unsigned NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 4'd3,  16'h0000, 3'b000, 16'hFFFF}, // R1 ones after reset
        '{2'd0, 1'b1, 4'd3,  16'h1234, 3'b011, 16'h0000}, // R4 both lanes
        '{2'd1, 1'b0, 4'd3,  16'h0000, 3'b000, 16'h1234}, // R11 seen by port 1
        '{2'd0, 1'b1, 4'd4,  16'hABCD, 3'b001, 16'h0000}, // R4 low lane only
        '{2'd0, 1'b0, 4'd4,  16'h0000, 3'b000, 16'hFFCD}, // R4
        '{2'd1, 1'b1, 4'd5,  16'h0000, 3'b100, 16'h0000}, // R5 narrow top lane
        '{2'd0, 1'b0, 4'd5,  16'h0000, 3'b000, 16'h0FFF}, // R5
        '{2'd1, 1'b1, 4'd5,  16'h0000, 3'b010, 16'h0000}, // R5 middle lane
        '{2'd1, 1'b0, 4'd5,  16'h0000, 3'b000, 16'h003F}, // R5
        '{2'd2, 1'b1, 4'd6,  16'h5A5A, 3'b000, 16'h0000}, // R6 mask ignored
        '{2'd0, 1'b0, 4'd6,  16'h0000, 3'b000, 16'h5A5A}, // R6
        '{2'd0, 1'b1, 4'd11, 16'h7777, 3'b011, 16'h0000}, // R4 top address
        '{2'd1, 1'b0, 4'd11, 16'h0000, 3'b000, 16'h7777}, // R11
        '{2'd0, 1'b1, 4'd12, 16'h0000, 3'b011, 16'h0000}, // R10 oob write
        '{2'd0, 1'b0, 4'd12, 16'h0000, 3'b000, 16'h0000}, // R10 oob read
        '{2'd0, 1'b0, 4'd0,  16'h0000, 3'b000, 16'hFFFF}  // R10 nothing aliased
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req = '0;
        we  = '0;
    endtask

    task automatic op(input int p, input logic w, input logic [3:0] a,
                      input logic [15:0] d, input logic [2:0] m);
        req[p]   = 1'b1;
        we[p]    = w;
        addr[p]  = a;
        wdata[p] = d;
        be[p]    = m;
    endtask

    task automatic drain();
        idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic read_chk(input int p, input logic [3:0] a,
                            input logic [15:0] exp, input string tag);
        int lat;
        lat = (p == 1) ? 3 : 1;
        op(p, 1'b0, a, 16'h0, 3'b000);
        @(negedge clk);
        idle();
        for (int i = 1; i < lat; i++) begin
            chk({tag, " R2 early valid"}, 16'(rvalid[p]), 16'd0);
            @(negedge clk);
        end
        chk({tag, " R2 valid"}, 16'(rvalid[p]), 16'd1);
        chk({tag, " data"}, rdata[p], exp);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = '0; we = '0; addr = '0; wdata = '0; be = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid clear in reset", 16'(rvalid), 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid clear after reset", 16'(rvalid), 16'd0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) begin
                op(int'(VECS[v].port), 1'b1, VECS[v].addr, VECS[v].data, VECS[v].mask);
                @(negedge clk);
                drain();
            end else begin
                read_chk(int'(VECS[v].port), VECS[v].addr, VECS[v].exp,
                         $sformatf("vec%0d", v));
            end
        end

        // R8: read-first on one port
        op(0, 1'b1, 4'd7, 16'h1111, 3'b111);
        @(negedge clk);
        idle();
        chk("R8 valid", 16'(rvalid[0]), 16'd1);
        chk("R8 old data", rdata[0], 16'hFFFF);
        drain();
        read_chk(0, 4'd7, 16'h1111, "R8 new data");

        // R9: three ports, same word, same cycle
        op(0, 1'b1, 4'd8, 16'hAAAA, 3'b111);
        op(1, 1'b1, 4'd8, 16'hBBBB, 3'b111);
        op(2, 1'b1, 4'd8, 16'hCCCC, 3'b000);
        @(negedge clk);
        drain();
        read_chk(0, 4'd8, 16'hCCCC, "R9 full overlap");

        // R9: partial overlap, port 1 takes bits 5:0 only
        op(0, 1'b1, 4'd9, 16'h1111, 3'b111);
        op(1, 1'b1, 4'd9, 16'h2222, 3'b001);
        @(negedge clk);
        drain();
        read_chk(0, 4'd9, 16'h1122, "R9 partial overlap");

        // R3: back-to-back reads on the 3-cycle port
        op(1, 1'b0, 4'd3, 16'h0, 3'b000);
        @(negedge clk);
        op(1, 1'b0, 4'd4, 16'h0, 3'b000);
        @(negedge clk);
        op(1, 1'b0, 4'd5, 16'h0, 3'b000);
        @(negedge clk);
        idle();
        chk("R3 first data", rdata[1], 16'h1234);
        @(negedge clk);
        chk("R3 second valid", 16'(rvalid[1]), 16'd1);
        chk("R3 second data", rdata[1], 16'hFFCD);
        @(negedge clk);
        chk("R3 third data", rdata[1], 16'h003F);
        @(negedge clk);
        chk("R3 valid drops", 16'(rvalid[1]), 16'd0);

        // R7: write-only port with write-enable low
        op(2, 1'b0, 4'd6, 16'hFFFF, 3'b111);
        @(negedge clk);
        idle();
        for (int i = 0; i < 3; i++) begin
            chk("R7 no valid", 16'(rvalid[2]), 16'd0);
            chk("R7 no data", rdata[2], 16'h0000);
            @(negedge clk);
        end
        read_chk(0, 4'd6, 16'h5A5A, "R7 word untouched");

        // R1: reset reloads contents
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        read_chk(0, 4'd3, 16'hFFFF, "R1 reload");
        read_chk(1, 4'd9, 16'hFFFF, "R1 reload port1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule